// File: doc/BRIEF.md
# Half-Iteration Sequencer for an Iterative Block Decoder

This block drives the address side of an iterative soft-decision decoder that works on one stored block at a time. After a start request it runs a fixed number of decoding iterations over the block. Each iteration has two halves. The odd half walks the block in natural order and takes its parity from the first parity bank. The even half walks the block in permuted order and takes its parity from the second parity bank. Each half issues one read per cycle to the symbol memory, the selected parity memory and the extrinsic (soft-value) memory.

In the even half the block sends its natural-order index to an external permutation source. That source returns the permuted address combinationally. The read addresses are grouped into windows of 16 or 32 symbols for the arithmetic pipeline that follows. The block marks the first address of each window and the end of each half. When the last iteration ends it raises a completion pulse, so the output stage can drain the block and input admission can reopen.

Top module: `halfiter_seq`

## Requirements
- R1: After the asynchronous reset, and while idle, `rd_en`, `win_start`, `half_done` and `done` are 0.
- R2: In the odd half (`half_even`=0, `par_sel`=0), the symbol, parity and extrinsic read addresses all equal the natural index, one per cycle with `rd_en`=1: 0, 1, …, blocklength−1.
- R3: In the even half (`half_even`=1, `par_sel`=1), the natural index is presented on `perm_idx`, and all three read addresses equal the value the permutation source returns on `perm_addr` in that cycle.
- R4: Every iteration is one odd half followed by one even half. `iter_num` reads 1 during the first iteration and rises by one per iteration. A run lasts exactly 2×blocklength×iterations read cycles, with no gap between halves.
- R5: `blk_len` and `iter_cfg` are sampled in the cycle `start` is accepted, and later changes do not affect the run in progress. An `iter_cfg` of 0 runs one iteration. Legal values are 1 to 15.
- R6: `win_start` is 1 on the first address of every half and on every address whose index within the half is a multiple of WIN. When blocklength is not a multiple of WIN, the last window is shorter.
- R7: `half_done` is a one-cycle pulse in the cycle after the last address of each half, and it occurs at no other time.
- R8: `done` is a one-cycle pulse in the cycle after the last address of the last even half. In that cycle `rd_en` is 0.
- R9: A `start` pulse while a run is in progress is ignored. No extra reads appear, and the run is neither restarted nor lengthened.
- R10: `sync_clr` ends any run. From the next cycle `rd_en` is 0, and no `done` pulse is produced for the aborted run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_clr | input | 1 | Synchronous abort to idle |
| start | input | 1 | Start a run (accepted when idle) |
| blk_len | input | LEN_W | Block length in symbols (≥1) |
| iter_cfg | input | 4 | Iteration count, 0 treated as 1 |
| perm_addr | input | LEN_W | Permuted address returned for `perm_idx` |
| perm_idx | output | LEN_W | Natural index sent to the permutation source |
| rd_en | output | 1 | Read strobe for all three memories |
| sym_addr | output | LEN_W | Symbol memory read address |
| par_addr | output | LEN_W | Parity memory read address |
| ext_addr | output | LEN_W | Extrinsic memory read address |
| par_sel | output | 1 | Parity bank: 0 first, 1 second |
| half_even | output | 1 | 1 during the even (permuted) half |
| iter_num | output | 4 | Current iteration number |
| win_start | output | 1 | First address of a window |
| half_done | output | 1 | Pulse after the last address of a half |
| done | output | 1 | Pulse after the final half |

## Verification
The block is run with a length of 40, which ends in a short window of 8, and with a length of 32, an exact multiple of the window. Comparing the two shows whether window boundaries come from the position inside the half or from a wrap of a free-running counter. Lengths 1, 3 and 5 test the degenerate single-address half, the full count of 15 iterations and an iteration setting of 0. These separate a comparison that is off by one on the last address or the iteration limit from a correct one. The permutation stub returns a scrambled order, so a natural-order read leaking into the even half is caught. Separate runs apply a stray `start`, an input change after acceptance and an abort in the middle of a half.

// File: rtl/hiseq_pkg.sv
package hiseq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/hs_pos_ctr.sv
// Position and in-window counter for one half pass.
module hs_pos_ctr #(
    parameter int LEN_W = 13,
    parameter int WIN   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [LEN_W-1:0] pos_o,
    output logic             win_first_o
);
    localparam int WIN_W = $clog2(WIN);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN - 1);

    typedef struct packed {
        logic [LEN_W-1:0] pos;
        logic [WIN_W-1:0] wc;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr_i) begin
            c_d.pos = '0;
            c_d.wc  = '0;
        end else if (adv_i) begin
            c_d.pos = c_q.pos + LEN_W'(1);
            c_d.wc  = (c_q.wc == WIN_LAST) ? '0 : c_q.wc + WIN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pos_o       = c_q.pos;
    assign win_first_o = (c_q.wc == '0);

    // R6: a full window rolls over into a new window start
    p_win_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i && c_q.wc == WIN_LAST) |=> win_first_o);

    // R2: a restart always returns the position to zero
    p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pos_o == '0));
endmodule

// File: rtl/hs_addr_mux.sv
// Picks natural or permuted order for each of the three read ports.
module hs_addr_mux #(
    parameter int AW = 13
) (
    input  logic          even_i,
    input  logic [AW-1:0] nat_i,
    input  logic [AW-1:0] perm_i,
    output logic [AW-1:0] sym_o,
    output logic [AW-1:0] par_o,
    output logic [AW-1:0] ext_o
);
    localparam int NPORT = 3;
    logic [NPORT-1:0][AW-1:0] sel;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign sel[g] = even_i ? perm_i : nat_i;
    end

    assign sym_o = sel[0];
    assign par_o = sel[1];
    assign ext_o = sel[2];
endmodule

// File: rtl/halfiter_seq.sv
module halfiter_seq #(
    parameter int LEN_W = 13,
    parameter int WIN   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_clr,
    input  logic             start,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [3:0]       iter_cfg,
    input  logic [LEN_W-1:0] perm_addr,
    output logic [LEN_W-1:0] perm_idx,
    output logic             rd_en,
    output logic [LEN_W-1:0] sym_addr,
    output logic [LEN_W-1:0] par_addr,
    output logic [LEN_W-1:0] ext_addr,
    output logic             par_sel,
    output logic             half_even,
    output logic [3:0]       iter_num,
    output logic             win_start,
    output logic             half_done,
    output logic             done
);
    import hiseq_pkg::*;

    typedef struct packed {
        seq_state_e       st;
        logic             even;
        logic [3:0]       iter;
        logic [3:0]       lim;
        logic [LEN_W-1:0] len;
        logic             hdone;
        logic             fin;
    } seq_t;

    seq_t s_d, s_q;
    logic             ctr_clr, ctr_adv, win_first, last_addr;
    logic [LEN_W-1:0] pos;

    hs_pos_ctr #(.LEN_W(LEN_W), .WIN(WIN)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (ctr_clr),
        .adv_i      (ctr_adv),
        .pos_o      (pos),
        .win_first_o(win_first)
    );

    hs_addr_mux #(.AW(LEN_W)) u_mux (
        .even_i(s_q.even),
        .nat_i (pos),
        .perm_i(perm_addr),
        .sym_o (sym_addr),
        .par_o (par_addr),
        .ext_o (ext_addr)
    );

    assign last_addr = (s_q.st == ST_RUN) && (pos == s_q.len - LEN_W'(1));

    always_comb begin
        s_d       = s_q;
        s_d.hdone = 1'b0;
        s_d.fin   = 1'b0;
        ctr_clr   = 1'b0;
        ctr_adv   = 1'b0;
        if (sync_clr) begin
            s_d.st   = ST_IDLE;
            s_d.even = 1'b0;
            ctr_clr  = 1'b1;
        end else begin
            case (s_q.st)
                ST_IDLE: begin
                    if (start) begin
                        s_d.st   = ST_RUN;
                        s_d.even = 1'b0;
                        s_d.iter = 4'd1;
                        s_d.lim  = (iter_cfg == 4'd0) ? 4'd1 : iter_cfg;
                        s_d.len  = (blk_len == '0) ? LEN_W'(1) : blk_len;
                        ctr_clr  = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (last_addr) begin
                        ctr_clr   = 1'b1;
                        s_d.hdone = 1'b1;
                        if (!s_q.even) begin
                            s_d.even = 1'b1;
                        end else if (s_q.iter == s_q.lim) begin
                            s_d.st   = ST_IDLE;
                            s_d.even = 1'b0;
                            s_d.fin  = 1'b1;
                        end else begin
                            s_d.even = 1'b0;
                            s_d.iter = s_q.iter + 4'd1;
                        end
                    end else begin
                        ctr_adv = 1'b1;
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.even  <= 1'b0;
            s_q.iter  <= 4'd0;
            s_q.lim   <= 4'd1;
            s_q.len   <= LEN_W'(1);
            s_q.hdone <= 1'b0;
            s_q.fin   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_en     = (s_q.st == ST_RUN);
    assign perm_idx  = pos;
    assign par_sel   = s_q.even;
    assign half_even = s_q.even;
    assign iter_num  = s_q.iter;
    assign win_start = rd_en && win_first;
    assign half_done = s_q.hdone;
    assign done      = s_q.fin;

    // R2: the natural index never leaves the block
    p_pos_in_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (pos < s_q.len));

    // R4: the iteration number stays within 1..limit while reading
    p_iter_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (iter_num >= 4'd1 && iter_num <= s_q.lim));

    // R7: a half ends only right after a read cycle
    p_hdone_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        half_done |-> $past(rd_en));

    // R8: completion coincides with the final half end and an idle read port
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (half_done && !rd_en));

    // R10: abort forces idle and suppresses completion
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (!rd_en && !done));

    // R4: the odd half is always followed by the even half
    p_odd_then_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (half_done && !$past(half_even) && !$past(sync_clr)) |-> (rd_en && half_even));
endmodule

// File: tb/halfiter_seq_bench.sv
module halfiter_seq_bench;
    localparam int LEN_W = 13;
    localparam int WIN   = 16;

    typedef struct {
        int addr;
        bit even;
        int iter;
        bit ws;
        bit last;
        bit fin;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sync_clr = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] blk_len = '0;
    logic [3:0]       iter_cfg = '0;
    logic [LEN_W-1:0] perm_addr;
    logic [LEN_W-1:0] perm_idx;
    logic             rd_en, par_sel, half_even, win_start, half_done, done;
    logic [LEN_W-1:0] sym_addr, par_addr, ext_addr;
    logic [3:0]       iter_num;

    int   total = 0;
    int   bad = 0;
    int   cur_len = 1;
    bit   mon_on = 0;
    bit   pend_last = 0;
    bit   pend_fin = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    halfiter_seq #(.LEN_W(LEN_W), .WIN(WIN)) u_halfiter_seq (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .start(start),
        .blk_len(blk_len), .iter_cfg(iter_cfg), .perm_addr(perm_addr),
        .perm_idx(perm_idx), .rd_en(rd_en), .sym_addr(sym_addr),
        .par_addr(par_addr), .ext_addr(ext_addr), .par_sel(par_sel),
        .half_even(half_even), .iter_num(iter_num), .win_start(win_start),
        .half_done(half_done), .done(done)
    );

    function automatic int perm_f(int idx, int len);
        return (idx * 5 + 3) % len;
    endfunction

    // permutation source stub
    always_comb perm_addr = LEN_W'(perm_f(int'(perm_idx), cur_len));

    task automatic chk(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // monitor: pops expected reads and checks half/done pulses
    always @(negedge clk) begin
        if (mon_on) begin
            if (pend_last) begin
                chk(half_done == 1'b1, "R7 half_done after last", int'(half_done), 1);
                chk(done == pend_fin, "R8 done pulse", int'(done), int'(pend_fin));
                if (pend_fin) chk(rd_en == 1'b0, "R8 rd_en low at done", int'(rd_en), 0);
            end else if (half_done || done) begin
                chk(1'b0, "R7 stray half_done/done", int'({half_done, done}), 0);
            end
            pend_last = 0;
            if (rd_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected read", int'(sym_addr), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(int'(sym_addr) == e.addr,
                        e.even ? "R3 sym_addr" : "R2 sym_addr", int'(sym_addr), e.addr);
                    chk(int'(par_addr) == e.addr && int'(ext_addr) == e.addr,
                        e.even ? "R3 par/ext addr" : "R2 par/ext addr", int'(par_addr), e.addr);
                    chk(par_sel == e.even && half_even == e.even, "R4 half order",
                        int'(half_even), int'(e.even));
                    chk(int'(iter_num) == e.iter, "R4 iter_num", int'(iter_num), e.iter);
                    chk(win_start == e.ws, "R6 win_start", int'(win_start), int'(e.ws));
                    pend_last = e.last;
                    pend_fin  = e.fin;
                end
            end
        end
    end

    task automatic push_run(int len, int cfg);
        int lim;
        lim = (cfg == 0) ? 1 : cfg;
        cur_len = len;
        for (int it = 1; it <= lim; it++) begin
            for (int h = 0; h < 2; h++) begin
                for (int i = 0; i < len; i++) begin
                    exp_t e;
                    e.addr = (h == 1) ? perm_f(i, len) : i;
                    e.even = (h == 1);
                    e.iter = it;
                    e.ws   = (i % WIN) == 0;
                    e.last = (i == len - 1);
                    e.fin  = e.last && (h == 1) && (it == lim);
                    exp_q.push_back(e);
                end
            end
        end
    endtask

    task automatic kick(int len, int cfg);
        @(negedge clk); #1;
        blk_len  = LEN_W'(len);
        iter_cfg = 4'(cfg);
        start    = 1'b1;
        @(negedge clk); #1;
        start    = 1'b0;
        blk_len  = LEN_W'(len + 7);   // R5: later change must not matter
        iter_cfg = 4'(cfg ^ 4'h5);
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0 || pend_last) @(posedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_block(int len, int cfg, bit poke);
        push_run(len, cfg);
        kick(len, cfg);
        if (poke) begin
            repeat (10) @(negedge clk);
            #1 start = 1'b1;           // R9: ignored while running
            @(negedge clk); #1 start = 1'b0;
        end
        wait_drain();
        chk(exp_q.size() == 0 && !rd_en, "R4 run length", exp_q.size(), 0);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!rd_en && !win_start && !half_done && !done, "R1 reset idle",
            int'({rd_en, win_start, half_done, done}), 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!rd_en && !done, "R1 idle after reset", int'({rd_en, done}), 0);
        mon_on = 1;

        run_block(40, 1, 0);   // R6 short last window
        run_block(32, 2, 0);   // R6 exact multiple
        run_block(5, 0, 0);    // R5 zero iterations -> one
        run_block(1, 3, 0);    // single-address halves
        run_block(3, 15, 0);   // R4 full count
        run_block(24, 2, 1);   // R9 stray start

        // R10 abort in the middle of an even half
        push_run(20, 2);
        kick(20, 2);
        repeat (25) @(negedge clk);
        #1 sync_clr = 1'b1;
        exp_q.delete();
        pend_last = 0;
        @(negedge clk); #1 sync_clr = 1'b0;
        chk(!rd_en, "R10 rd_en low after abort", int'(rd_en), 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(!done && !rd_en, "R10 no done after abort", int'({done, rd_en}), 0);
        end

        run_block(17, 1, 0);   // recovery after abort

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule